// File: doc/BRIEF.md
# Multi-Lane I2S Bus Master Transceiver

This block is the master of an I2S audio bus. It runs entirely from one incoming master clock. From that clock it makes the bit clock and the word clock and drives both off chip. Several serial output lanes and several serial input lanes share those two clocks. Each lane carries one stereo pair per frame, so every channel on the bus stays aligned to the same frame.

On the system side, one ready/valid beat carries a whole frame: a left and a right sample for every output lane. One beat is also returned for each received frame, holding every input channel. Samples are 32-bit signed and left-aligned, so a shorter sample sits in the upper bits and its unused low bits are zero. The block loads output samples only at frame boundaries. When no new output samples are waiting, it sends silence. When the system falls behind in taking received frames, the block flags the loss.

Top module: `i2s_lane_master`

## Requirements
- R1: While reset is held and directly after it is released, `bclk_o`, `wclk_o` and every `sd_o` bit are low, `rx_valid_o` and `rx_overflow_o` are low, and `tx_ready_o` is high.
- R2: The bit clock has a period of `RATIO` master clock cycles. It is high for `RATIO/2` cycles and low for `RATIO/2` cycles.
- R3: A frame is 64 bit-clock periods: 32 for the left slot and then 32 for the right slot. Number the periods from 0, where period 0 carries the left MSB. `wclk_o` is high in periods 31 to 62 and low in all other periods, so it changes one period before each slot's MSB.
- R4: The first falling edge of the bit clock after reset begins period 0 of the first frame.
- R5: Serial output data changes only together with a falling bit-clock edge. Each slot is sent MSB first, 32 bits.
- R6: A `tx_data_i` beat holds one frame. Channel k = 2*lane + side (side 0 is left, side 1 is right) occupies bits [32k+31:32k]. Each sample appears on its lane bit-exact, including sign bits and zero low bits.
- R7: `tx_ready_o` is high only when the one-frame holding buffer is empty. An accepted beat fills the buffer and drops `tx_ready_o`. At the start of the next frame the buffer moves to the lane shifters and `tx_ready_o` rises again.
- R8: If the holding buffer is empty when a frame starts, every output lane sends zeros for that whole frame.
- R9: Input lanes are sampled on rising bit-clock edges. Each complete frame is offered on `rx_data_o` at the rising edge of its last period, with the same channel packing as R6. The first beat offered is the first complete frame after reset.
- R10: `rx_valid_o` stays high with stable data until `rx_ready_i` is seen high. Exactly one beat is offered per frame.
- R11: If a frame completes while the previous beat is still pending and not being accepted, `rx_overflow_o` is set. It stays set until reset, and the pending beat is replaced by the newest frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock; all logic runs on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_valid_i | input | 1 | Output-frame beat is valid |
| tx_ready_o | output | 1 | Holding buffer can take a frame |
| tx_data_i | input | 64*N_TX | One frame of output samples, packed per R6 |
| rx_valid_o | output | 1 | Received frame is available |
| rx_ready_i | input | 1 | System takes the received frame |
| rx_data_o | output | 64*N_RX | One frame of input samples, packed per R6 |
| rx_overflow_o | output | 1 | Sticky flag: a received frame was lost |
| bclk_o | output | 1 | Bit clock |
| wclk_o | output | 1 | Word clock (low left, high right) |
| sd_o | output | N_TX | Serial data, one bit per output lane |
| sd_i | input | N_RX | Serial data, one bit per input lane |

## Verification
The bench builds the block with a divide ratio of 4, two output lanes and three input lanes. With a ratio of 4, each bit-clock phase lasts two master cycles, so the bench can see whether data moves in the middle of a phase. The unequal lane counts mean that swapped lane or side indices, or a packing error on either stream, produce wrong values instead of cancelling out. A model of a codec, clocked by the block's own clocks, drives distinct patterns per frame, lane and side. The bench stalls the receive stream for two frames to reach the overflow case.

// File: rtl/i2s_lane_pkg.sv
package i2s_lane_pkg;
   localparam int SLOT_W     = 32;
   localparam int FRAME_BITS = 2 * SLOT_W;
   localparam int POS_W      = $clog2(FRAME_BITS);
   localparam logic [POS_W-1:0] POS_LAST   = POS_W'(FRAME_BITS - 1);
   localparam logic [POS_W-1:0] WCLK_RISE  = POS_W'(SLOT_W - 1);
   localparam logic [POS_W-1:0] WCLK_FALL  = POS_W'(FRAME_BITS - 1);
endpackage

// File: rtl/i2s_bit_timer.sv
module i2s_bit_timer
   import i2s_lane_pkg::*;
#(
   parameter int RATIO = 4
) (
   input  logic clk_i,
   input  logic rst_ni,
   output logic bclk_o,
   output logic wclk_o,
   output logic rise_o,
   output logic fall_o,
   output logic frame_start_o,
   output logic frame_end_o
);
   localparam int HALF = RATIO / 2;
   localparam int DW   = (RATIO > 2) ? $clog2(RATIO) : 1;

   logic [DW-1:0]    div_q;
   logic [POS_W-1:0] pos_q;
   logic [POS_W-1:0] pos_nxt;
   logic             bclk_q;
   logic             wclk_q;

   assign rise_o        = (div_q == DW'(HALF - 1));
   assign fall_o        = (div_q == DW'(RATIO - 1));
   assign pos_nxt       = pos_q + 1'b1;
   assign frame_start_o = fall_o && (pos_q == POS_LAST);
   assign frame_end_o   = rise_o && (pos_q == POS_LAST);
   assign bclk_o        = bclk_q;
   assign wclk_o        = wclk_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         div_q  <= '0;
         pos_q  <= POS_LAST;
         bclk_q <= 1'b0;
         wclk_q <= 1'b0;
      end else begin
         div_q <= fall_o ? '0 : div_q + 1'b1;
         if (rise_o) bclk_q <= 1'b1;
         if (fall_o) begin
            bclk_q <= 1'b0;
            pos_q  <= pos_nxt;
            wclk_q <= (pos_nxt >= WCLK_RISE) && (pos_nxt < WCLK_FALL);
         end
      end
   end

   // R2
   pos_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(pos_q) |-> $fell(bclk_q));
   // R3
   wclk_pos_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(wclk_q) |-> (pos_q == WCLK_RISE || pos_q == WCLK_FALL));
endmodule

// File: rtl/i2s_tx_lane.sv
module i2s_tx_lane
   import i2s_lane_pkg::*;
(
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  fall_i,
   input  logic                  load_i,
   input  logic [FRAME_BITS-1:0] frame_i,
   output logic                  sd_o
);
   logic [FRAME_BITS-1:0] sh_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     sh_q <= '0;
      else if (load_i) sh_q <= frame_i;
      else if (fall_i) sh_q <= {sh_q[FRAME_BITS-2:0], 1'b0};
   end

   assign sd_o = sh_q[FRAME_BITS-1];

   // R5
   sd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !fall_i |=> $stable(sd_o));
endmodule

// File: rtl/i2s_rx_lane.sv
module i2s_rx_lane
   import i2s_lane_pkg::*;
(
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  rise_i,
   input  logic                  sd_i,
   output logic [FRAME_BITS-1:0] frame_o
);
   logic [FRAME_BITS-2:0] sh_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     sh_q <= '0;
      else if (rise_i) sh_q <= {sh_q[FRAME_BITS-3:0], sd_i};
   end

   // value the shifter will hold after this rising edge
   assign frame_o = {sh_q, sd_i};
endmodule

// File: rtl/i2s_lane_master.sv
module i2s_lane_master
   import i2s_lane_pkg::*;
#(
   parameter int RATIO = 4,
   parameter int N_TX  = 4,
   parameter int N_RX  = 3
) (
   input  logic                         clk_i,
   input  logic                         rst_ni,
   input  logic                         tx_valid_i,
   output logic                         tx_ready_o,
   input  logic [FRAME_BITS*N_TX-1:0]   tx_data_i,
   output logic                         rx_valid_o,
   input  logic                         rx_ready_i,
   output logic [FRAME_BITS*N_RX-1:0]   rx_data_o,
   output logic                         rx_overflow_o,
   output logic                         bclk_o,
   output logic                         wclk_o,
   output logic [N_TX-1:0]              sd_o,
   input  logic [N_RX-1:0]              sd_i
);
   localparam int TXW = FRAME_BITS * N_TX;
   localparam int RXW = FRAME_BITS * N_RX;

   if (RATIO < 2 || (RATIO % 2) != 0) begin : g_bad_ratio
      $error("RATIO must be even and at least 2");
   end
   if (N_TX < 1 || N_RX < 1) begin : g_bad_lanes
      $error("lane counts must be at least 1");
   end

   logic rise, fall, frame_start, frame_end;

   i2s_bit_timer #(.RATIO(RATIO)) u_timer (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .bclk_o        (bclk_o),
      .wclk_o        (wclk_o),
      .rise_o        (rise),
      .fall_o        (fall),
      .frame_start_o (frame_start),
      .frame_end_o   (frame_end)
   );

   // transmit side: one-frame holding buffer
   logic [TXW-1:0] hold_q;
   logic           hold_full_q;

   assign tx_ready_o = !hold_full_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         hold_q      <= '0;
         hold_full_q <= 1'b0;
      end else if (tx_valid_i && !hold_full_q) begin
         hold_q      <= tx_data_i;
         hold_full_q <= 1'b1;
      end else if (frame_start) begin
         hold_full_q <= 1'b0;
      end
   end

   for (genvar l = 0; l < N_TX; l++) begin : g_tx
      logic [FRAME_BITS-1:0] load_val;
      assign load_val = hold_full_q
         ? {hold_q[(2*l)*SLOT_W +: SLOT_W], hold_q[(2*l+1)*SLOT_W +: SLOT_W]}
         : '0;
      i2s_tx_lane u_lane (
         .clk_i   (clk_i),
         .rst_ni  (rst_ni),
         .fall_i  (fall),
         .load_i  (frame_start),
         .frame_i (load_val),
         .sd_o    (sd_o[l])
      );
   end

   // receive side
   logic [RXW-1:0] rx_next;

   for (genvar l = 0; l < N_RX; l++) begin : g_rx
      logic [FRAME_BITS-1:0] lane_frame;
      i2s_rx_lane u_lane (
         .clk_i   (clk_i),
         .rst_ni  (rst_ni),
         .rise_i  (rise),
         .sd_i    (sd_i[l]),
         .frame_o (lane_frame)
      );
      assign rx_next[(2*l)*SLOT_W   +: SLOT_W] = lane_frame[FRAME_BITS-1:SLOT_W];
      assign rx_next[(2*l+1)*SLOT_W +: SLOT_W] = lane_frame[SLOT_W-1:0];
   end

   logic           armed_q;
   logic           rx_valid_q;
   logic           ovf_q;
   logic [RXW-1:0] rx_data_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         armed_q    <= 1'b0;
         rx_valid_q <= 1'b0;
         ovf_q      <= 1'b0;
         rx_data_q  <= '0;
      end else begin
         if (frame_start) armed_q <= 1'b1;
         if (frame_end && armed_q) begin
            rx_data_q  <= rx_next;
            rx_valid_q <= 1'b1;
            if (rx_valid_q && !rx_ready_i) ovf_q <= 1'b1;
         end else if (rx_ready_i) begin
            rx_valid_q <= 1'b0;
         end
      end
   end

   assign rx_valid_o    = rx_valid_q;
   assign rx_data_o     = rx_data_q;
   assign rx_overflow_o = ovf_q;

   // R7
   tx_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tx_valid_i && tx_ready_o |=> !tx_ready_o);
   // R9
   rx_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rx_valid_o) |-> $rose(bclk_o));
   // R10
   rx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rx_valid_o && !rx_ready_i |=> rx_valid_o);
   // R11
   ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rx_overflow_o |=> rx_overflow_o);
endmodule

// File: tb/i2s_lane_master_tb.sv
module i2s_lane_master_tb;
   localparam int RATIO = 4;
   localparam int N_TX  = 2;
   localparam int N_RX  = 3;
   localparam int TXW   = 64 * N_TX;
   localparam int RXW   = 64 * N_RX;

   logic            clk = 1'b0;
   logic            rst_ni = 1'b0;
   logic            tx_valid = 1'b0;
   logic            tx_ready;
   logic [TXW-1:0]  tx_data = '0;
   logic            rx_valid;
   logic            rx_rdy = 1'b1;
   logic [RXW-1:0]  rx_data;
   logic            rx_ovf;
   logic            bclk_o, wclk_o;
   logic [N_TX-1:0] sd_o;
   logic [N_RX-1:0] sd_i = '0;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   i2s_lane_master #(.RATIO(RATIO), .N_TX(N_TX), .N_RX(N_RX)) u_dut (
      .clk_i(clk), .rst_ni(rst_ni),
      .tx_valid_i(tx_valid), .tx_ready_o(tx_ready), .tx_data_i(tx_data),
      .rx_valid_o(rx_valid), .rx_ready_i(rx_rdy), .rx_data_o(rx_data),
      .rx_overflow_o(rx_ovf), .bclk_o(bclk_o), .wclk_o(wclk_o),
      .sd_o(sd_o), .sd_i(sd_i)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [255:0] act, input logic [255:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] rx_pat(int f, int l, int side);
      return {side ? 4'hE : 4'h3, 4'(l), 8'(f * 7 + 1), 8'hA5, 8'h5A};
   endfunction

   function automatic logic [RXW-1:0] rx_frame(int f);
      logic [RXW-1:0] v;
      for (int l = 0; l < N_RX; l++) begin
         v[(2*l)*32   +: 32] = rx_pat(f, l, 0);
         v[(2*l+1)*32 +: 32] = rx_pat(f, l, 1);
      end
      return v;
   endfunction

   function automatic logic [TXW-1:0] tx_frame(int f);
      logic [TXW-1:0] v;
      for (int k = 0; k < 2 * N_TX; k++)
         v[k*32 +: 32] = 32'h8035_A900 ^ (32'(f) << 24) ^ (32'(k + 1) << 12);
      return v;
   endfunction

   // codec model clocked by the block's own bit and word clocks
   int per = 63;
   int fc = -1;
   int completed = 0;
   int w_err = 0;
   int w_cnt = 0;
   int s_err = 0;
   logic [N_TX-1:0] sd_at_rise = '0;
   logic [63:0] cur_tx [N_TX];
   logic [63:0] cap_tx [8][N_TX];
   logic [31:0] drv_word;

   always @(negedge bclk_o) begin
      if (rst_ni) begin
         per = (per + 1) % 64;
         if (per == 0) fc++;
         for (int l = 0; l < N_RX; l++) begin
            drv_word = rx_pat(fc, l, (per >= 32) ? 1 : 0);
            sd_i[l] = drv_word[31 - (per % 32)];
         end
      end
   end

   always @(posedge bclk_o) begin
      if (rst_ni) begin
         w_cnt++;
         if (wclk_o !== ((per >= 31 && per <= 62) ? 1'b1 : 1'b0)) w_err++;
         sd_at_rise = sd_o;
         for (int l = 0; l < N_TX; l++) cur_tx[l][63 - per] = sd_o[l];
         if (per == 63) begin
            if (fc >= 0 && fc < 8)
               for (int l = 0; l < N_TX; l++) cap_tx[fc][l] = cur_tx[l];
            completed = fc + 1;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_ni && bclk_o === 1'b1 && sd_o !== sd_at_rise) s_err++;
   end

   // receive-stream consumer
   int dcount = 0;
   int first_f = -1;
   int last_f = -1;
   always @(negedge clk) begin
      if (rst_ni && rx_valid === 1'b1 && rx_rdy) begin
         if (dcount == 0) first_f = completed - 1;
         last_f = completed - 1;
         dcount++;
         chk(rx_data === rx_frame(completed - 1), "R9",
             "received frame content", 256'(rx_data), 256'(rx_frame(completed - 1)));
      end
   end

   task automatic set_rdy(input logic v);
      @(posedge clk);
      #2 rx_rdy = v;
   endtask

   task automatic push(input logic [TXW-1:0] d);
      @(negedge clk);
      tx_valid = 1'b1;
      tx_data  = d;
      while (!tx_ready) @(negedge clk);
      @(negedge clk);
      tx_valid = 1'b0;
   endtask

   task automatic wait_done(input int n);
      while (completed < n) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   task automatic t_reset;
      repeat (5) @(negedge clk);
      chk(bclk_o === 1'b0 && wclk_o === 1'b0 && sd_o === '0, "R1",
          "clocks and data low in reset", 256'({bclk_o, wclk_o, sd_o}), 256'(0));
      rst_ni = 1'b1;
      chk(rx_valid === 1'b0, "R1", "rx_valid after reset", 256'(rx_valid), 256'(0));
      chk(rx_ovf === 1'b0, "R1", "overflow after reset", 256'(rx_ovf), 256'(0));
      chk(tx_ready === 1'b1, "R1", "tx_ready after reset", 256'(tx_ready), 256'(1));
   endtask

   task automatic t_clock;
      int hi = 0;
      int lo = 0;
      while (bclk_o !== 1'b0) @(negedge clk);
      while (bclk_o !== 1'b1) @(negedge clk);
      while (bclk_o === 1'b1) begin hi++; @(negedge clk); end
      while (bclk_o === 1'b0) begin lo++; @(negedge clk); end
      chk(hi == RATIO / 2, "R2", "bit clock high time", 256'(hi), 256'(RATIO / 2));
      chk(lo == RATIO / 2, "R2", "bit clock low time", 256'(lo), 256'(RATIO / 2));
   endtask

   task automatic t_tx;
      logic [TXW-1:0] exp_f [5];
      push(tx_frame(0));
      chk(tx_ready === 1'b0, "R7", "ready low while buffer full", 256'(tx_ready), 256'(0));
      exp_f[0] = tx_frame(0);
      t_clock();
      push(tx_frame(1));
      exp_f[1] = tx_frame(1);
      chk(tx_ready === 1'b0, "R7", "ready low after second beat", 256'(tx_ready), 256'(0));
      push(tx_frame(2));
      exp_f[2] = tx_frame(2);
      exp_f[3] = '0;
      while (fc < 3) @(negedge clk);
      chk(tx_ready === 1'b1, "R7", "ready high after buffer drained", 256'(tx_ready), 256'(1));
      push(tx_frame(4));
      exp_f[4] = tx_frame(4);
      wait_done(5);
      for (int f = 0; f < 5; f++) begin
         for (int l = 0; l < N_TX; l++) begin
            logic [63:0] e;
            e = {exp_f[f][(2*l)*32 +: 32], exp_f[f][(2*l+1)*32 +: 32]};
            chk(cap_tx[f][l] === e, (f == 3) ? "R8" : ((f == 0) ? "R4" : "R6"),
                $sformatf("tx frame %0d lane %0d", f, l), 256'(cap_tx[f][l]), 256'(e));
         end
      end
   endtask

   task automatic t_rx_flow;
      chk(first_f == 0, "R9", "first delivered frame index", 256'(first_f), 256'(0));
      chk(dcount == 5, "R10", "one beat per frame", 256'(dcount), 256'(5));
   endtask

   task automatic t_overflow;
      int k;
      int d0;
      while (fc < 6) @(negedge clk);
      set_rdy(1'b0);
      k = completed;
      wait_done(k + 1);
      chk(rx_valid === 1'b1, "R10", "beat held while not ready", 256'(rx_valid), 256'(1));
      chk(rx_ovf === 1'b0, "R11", "no overflow with one pending", 256'(rx_ovf), 256'(0));
      wait_done(k + 2);
      chk(rx_ovf === 1'b1, "R11", "overflow set on lost frame", 256'(rx_ovf), 256'(1));
      d0 = dcount;
      set_rdy(1'b1);
      repeat (3) @(negedge clk);
      chk(last_f == k + 1, "R11", "pending beat replaced by newest", 256'(last_f), 256'(k + 1));
      wait_done(k + 4);
      chk(rx_ovf === 1'b1, "R11", "overflow stays set", 256'(rx_ovf), 256'(1));
      chk(dcount == d0 + 3, "R10", "delivery resumes per frame", 256'(dcount), 256'(d0 + 3));
   endtask

   task automatic summary;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      t_reset();
      t_tx();
      t_rx_flow();
      t_overflow();
      chk(w_err == 0 && w_cnt > 0, "R3", "word clock per period", 256'(w_err), 256'(0));
      chk(s_err == 0, "R5", "data stable while bit clock high", 256'(s_err), 256'(0));
      summary();
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end
endmodule